// File: doc/BRIEF.md
# Double-Edge Serial-to-Parallel Word Deserializer

This block converts a one-bit serial stream into parallel words. The line is sampled on both edges of a fast bit clock that runs at a fixed multiple (`RATIO`, default 4) of a slower word clock. Each word-clock period therefore yields `2*RATIO` bits, eight by default. The two clocks are taken to come from one PLL, so they are phase-related. The samples are packed in the fast domain. A holding register is loaded one fast cycle ahead of each word-clock edge and then copied into the word-clock output register. This gives the slow domain a full fast cycle of setup and a full fast cycle of hold.

Once the clock has locked, the bit phase of the data relative to the word boundary is still unknown. A boundary offset register fixes this: each slip request moves the boundary by one bit position. Slips can come from outside, or from an internal search. The search compares each valid word with a programmable training pattern and issues slips until a word matches. It then raises an aligned flag.

Top module: `dser_ddr_deserializer`

## Requirements
- R1: While `lock_i` is sampled low on a word-clock edge, the outputs after that edge are `word_o` = 0, `valid_o` = 0 and `aligned_o` = 0, and the boundary offset returns to 0.
- R2: After `lock_i` is first sampled high on a word-clock edge, `valid_o` stays low after the first and second following word-clock edges and goes high after the third. It then stays high for as long as `lock_i` is high.
- R3: Within a fast cycle, the sample taken on the rising edge is earlier in the stream than the sample taken on the falling edge. Each word holds 8 consecutive stream bits, with the earliest bit in bit 7 (MSB) and the latest in bit 0. Consecutive valid words cover contiguous, non-overlapping stretches of the stream.
- R4: Each word-clock edge that samples `slip_i` high adds one to the boundary offset, modulo 8. The word registered on the next word-clock edge then begins one stream bit earlier than it would have without the slip. Eight slips restore the original boundary.
- R5: At offset 0, bit 0 of the word registered on a word-clock edge is the falling-edge sample taken 1.5 fast-clock periods before that edge. Each unit of offset moves the whole word one bit earlier in the stream.
- R6: While `search_en_i` is high, `valid_o` is high and no match has been found, a compared word that differs from `train_pat_i` causes exactly one internal slip. The next two words are not compared, and the third is. The first comparison uses the word present when `valid_o` has been high for one edge.
- R7: `aligned_o` rises on the word-clock edge after a compared word equals `train_pat_i`. It stays high while `search_en_i` stays high. It falls on the first word-clock edge that samples `search_en_i` low.
- R8: With `search_en_i` low, no internal slip occurs. The offset changes only through `slip_i`, and `aligned_o` stays low.
- R9: Once aligned, no further internal slips occur: a repeating training stream yields `train_pat_i` in every later word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk_i | input | 1 | Fast bit clock, RATIO times the word clock, edges aligned with it |
| wclk_i | input | 1 | Word clock |
| lock_i | input | 1 | Clock-locked indication, active-low synchronous reset for both domains |
| sdi_i | input | 1 | Serial data line, sampled on both fast-clock edges |
| slip_i | input | 1 | External request to move the word boundary by one bit (word-clock domain) |
| search_en_i | input | 1 | Enables the automatic training-pattern search |
| train_pat_i | input | 2*RATIO | Training pattern that the search looks for |
| word_o | output | 2*RATIO | Parallel word, earliest bit in the MSB |
| valid_o | output | 1 | Word output carries stream data |
| aligned_o | output | 1 | Search has found the training pattern |

## Verification
The assertions take three things for granted. First, the fast and word clocks have fixed edges, with each word-clock rising edge coinciding with a fast rising edge. Second, `lock_i` changes shortly after a word-clock edge, so both domains see its release within the same word period. Third, `train_pat_i` stays constant during a search. The bench builds both clocks from one time base with exactly that relation. It changes `lock_i`, `slip_i` and `search_en_i` half a nanosecond to a nanosecond after a word-clock edge, and changes `sdi_i` midway between fast edges. It sweeps every boundary offset by hand and every one of the eight stream phases through the automatic search. Its expectations come from a stream-index formula rather than from the design.

// File: rtl/dser_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the double-edge deserializer.
// Assumes nothing beyond being compiled before the modules that import it.
package dser_pkg;

    // Word-clock edges with lock high before valid_o rises
    localparam int VALID_EDGES = 3;

    // Words skipped after an automatic slip before the next comparison
    localparam int SETTLE_WORDS = 2;

    // Search controller states
    typedef enum logic [1:0] {
        ALN_SEARCH = 2'd0,
        ALN_SETTLE = 2'd1,
        ALN_DONE   = 2'd2
    } aln_state_e;

endpackage

// File: rtl/dser_ddr_capture.sv
`timescale 1ns/1ps
// Module: dser_ddr_capture
// Samples the serial line on the rising and on the falling edge of the fast
// clock. Assumes the line is stable around both edges. Data-path only, so
// no reset: the packer downstream is reset instead.
module dser_ddr_capture (
    input  logic fclk_i,
    input  logic sdi_i,
    output logic rise_q_o,
    output logic fall_q_o
);

    // Rising-edge sample (earlier bit of each fast-cycle pair)
    always_ff @(posedge fclk_i) begin
        rise_q_o <= sdi_i;
    end

    // Falling-edge sample (later bit of each fast-cycle pair)
    always_ff @(negedge fclk_i) begin
        fall_q_o <= sdi_i;
    end

endmodule

// File: rtl/dser_gearbox.sv
`timescale 1ns/1ps
// Module: dser_gearbox
// Fast-domain packer. Shifts each pair of samples into a history register and,
// one fast cycle before every word-clock edge, loads a holding register with
// the BITS-wide window chosen by the boundary offset. Assumes the fast clock
// is RATIO times the word clock with rising edges coincident, and that the
// reset is released just after a word-clock edge.
module dser_gearbox #(
    parameter  int RATIO = 4,
    localparam int BITS  = 2 * RATIO,
    localparam int OFFW  = $clog2(BITS)
) (
    input  logic            fclk_i,
    input  logic            rst_n,
    input  logic            rise_i,
    input  logic            fall_i,
    input  logic [OFFW-1:0] offset_i,
    output logic [BITS-1:0] hold_o
);

    localparam int HW   = 2 * BITS;
    localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST_PH = CW'(RATIO - 1);
    localparam logic [CW-1:0] LOAD_PH = CW'(RATIO - 2);

    logic [CW-1:0] phase_q;
    logic [HW-1:0] hist_q;
    logic [HW-1:0] hist_nxt;

    // Newest pair enters at the bottom, rising-edge sample above falling
    always_comb begin
        hist_nxt = {hist_q[HW-3:0], rise_i, fall_i};
    end

    // Fast-cycle position within the current word period
    always_ff @(posedge fclk_i) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST_PH) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Sample history shift register
    always_ff @(posedge fclk_i) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_nxt;
        end
    end

    // Holding register, loaded one fast cycle ahead of the word-clock edge
    always_ff @(posedge fclk_i) begin
        if (!rst_n) begin
            hold_o <= '0;
        end else if (phase_q == LOAD_PH) begin
            hold_o <= hist_nxt[offset_i +: BITS];
        end
    end

endmodule

// File: rtl/dser_word_stage.sv
`timescale 1ns/1ps
// Module: dser_word_stage
// Word-clock domain output stage. Registers the holding word, keeps the
// boundary offset and produces the valid strobe. Assumes the holding
// register is stable across each word-clock edge.
module dser_word_stage
    import dser_pkg::*;
#(
    parameter  int BITS = 8,
    localparam int OFFW = $clog2(BITS)
) (
    input  logic            wclk_i,
    input  logic            rst_n,
    input  logic [BITS-1:0] hold_i,
    input  logic            slip_i,
    output logic [OFFW-1:0] offset_o,
    output logic [BITS-1:0] word_o,
    output logic            valid_o
);

    localparam logic [OFFW-1:0] OFF_MAX = OFFW'(BITS - 1);
    localparam logic [1:0]      V_LAST  = 2'(VALID_EDGES - 1);

    logic [1:0] vcnt_q;

    // Boundary offset, one step per sampled slip, wrapping at BITS
    always_ff @(posedge wclk_i) begin
        if (!rst_n) begin
            offset_o <= '0;
        end else if (slip_i) begin
            offset_o <= (offset_o == OFF_MAX) ? '0 : offset_o + 1'b1;
        end
    end

    // Parallel output register
    always_ff @(posedge wclk_i) begin
        if (!rst_n) begin
            word_o <= '0;
        end else begin
            word_o <= hold_i;
        end
    end

    // Warm-up counter and valid strobe
    always_ff @(posedge wclk_i) begin
        if (!rst_n) begin
            vcnt_q  <= '0;
            valid_o <= 1'b0;
        end else begin
            if (vcnt_q != V_LAST) begin
                vcnt_q <= vcnt_q + 1'b1;
            end
            valid_o <= (vcnt_q == V_LAST);
        end
    end

endmodule

// File: rtl/dser_aligner.sv
`timescale 1ns/1ps
// Module: dser_aligner
// Training-pattern search. Compares valid words with the pattern, issues a
// one-cycle slip on mismatch, waits for the slipped word to reach the output,
// and latches an aligned state on a match. Assumes the pattern is constant
// during a search.
module dser_aligner
    import dser_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            wclk_i,
    input  logic            rst_n,
    input  logic            search_en_i,
    input  logic [BITS-1:0] pattern_i,
    input  logic [BITS-1:0] word_i,
    input  logic            valid_i,
    output logic            slip_o,
    output logic            aligned_o
);

    aln_state_e state_q;
    logic [1:0] settle_q;

    // Search state machine with settle window after each slip
    always_ff @(posedge wclk_i) begin
        if (!rst_n || !search_en_i) begin
            state_q  <= ALN_SEARCH;
            settle_q <= '0;
            slip_o   <= 1'b0;
        end else begin
            slip_o <= 1'b0;
            case (state_q)
                ALN_SEARCH: begin
                    if (valid_i) begin
                        if (word_i == pattern_i) begin
                            state_q <= ALN_DONE;
                        end else begin
                            slip_o   <= 1'b1;
                            settle_q <= 2'(SETTLE_WORDS);
                            state_q  <= ALN_SETTLE;
                        end
                    end
                end
                ALN_SETTLE: begin
                    settle_q <= settle_q - 1'b1;
                    if (settle_q == 2'd1) begin
                        state_q <= ALN_SEARCH;
                    end
                end
                default: begin
                    state_q <= ALN_DONE;
                end
            endcase
        end
    end

    // Aligned flag decoded from the state register
    always_comb begin
        aligned_o = (state_q == ALN_DONE);
    end

endmodule

// File: rtl/dser_ddr_deserializer.sv
`timescale 1ns/1ps
// Module: dser_ddr_deserializer (top)
// Double-edge serial-to-parallel converter with word-boundary slip and an
// automatic training search. Assumes phase-related clocks (fast = RATIO x
// word, rising edges coincident) and lock_i changing just after a word edge.
module dser_ddr_deserializer #(
    parameter  int RATIO = 4,
    localparam int BITS  = 2 * RATIO
) (
    input  logic            fclk_i,
    input  logic            wclk_i,
    input  logic            lock_i,
    input  logic            sdi_i,
    input  logic            slip_i,
    input  logic            search_en_i,
    input  logic [BITS-1:0] train_pat_i,
    output logic [BITS-1:0] word_o,
    output logic            valid_o,
    output logic            aligned_o
);

    localparam int OFFW = $clog2(BITS);

    logic            rise_q;
    logic            fall_q;
    logic [BITS-1:0] hold_w;
    logic [OFFW-1:0] offset_w;
    logic            auto_slip;
    logic            slip_any;

    // Manual and automatic slips share the boundary counter
    always_comb begin
        slip_any = slip_i | auto_slip;
    end

    dser_ddr_capture cap_i (
        .fclk_i   (fclk_i),
        .sdi_i    (sdi_i),
        .rise_q_o (rise_q),
        .fall_q_o (fall_q)
    );

    dser_gearbox #(.RATIO(RATIO)) gbx_i (
        .fclk_i   (fclk_i),
        .rst_n    (lock_i),
        .rise_i   (rise_q),
        .fall_i   (fall_q),
        .offset_i (offset_w),
        .hold_o   (hold_w)
    );

    dser_word_stage #(.BITS(BITS)) wst_i (
        .wclk_i   (wclk_i),
        .rst_n    (lock_i),
        .hold_i   (hold_w),
        .slip_i   (slip_any),
        .offset_o (offset_w),
        .word_o   (word_o),
        .valid_o  (valid_o)
    );

    dser_aligner #(.BITS(BITS)) aln_i (
        .wclk_i      (wclk_i),
        .rst_n       (lock_i),
        .search_en_i (search_en_i),
        .pattern_i   (train_pat_i),
        .word_i      (word_o),
        .valid_i     (valid_o),
        .slip_o      (auto_slip),
        .aligned_o   (aligned_o)
    );

endmodule

// File: rtl/dser_ddr_deserializer_chk.sv
`timescale 1ns/1ps
// Module: dser_ddr_deserializer_chk
// Port-level temporal checks for the deserializer, bound to the top module.
// Assumes lock_i is driven to a known value from time zero.
module dser_ddr_deserializer_chk #(
    parameter int BITS = 8
) (
    input logic            wclk_i,
    input logic            lock_i,
    input logic            search_en_i,
    input logic [BITS-1:0] train_pat_i,
    input logic [BITS-1:0] word_o,
    input logic            valid_o,
    input logic            aligned_o
);

    // R1
    reset_clear_chk: assert property (@(posedge wclk_i)
        !lock_i |=> (!valid_o && word_o == '0 && !aligned_o));

    // R2
    valid_hold_chk: assert property (@(posedge wclk_i) disable iff (!lock_i)
        valid_o |=> valid_o);

    // R7
    match_before_align_chk: assert property (@(posedge wclk_i) disable iff (!lock_i)
        $rose(aligned_o) |-> $past(word_o == train_pat_i));

    // R7
    align_sticky_chk: assert property (@(posedge wclk_i) disable iff (!lock_i)
        (aligned_o && search_en_i) |=> aligned_o);

    // R6
    align_needs_valid_chk: assert property (@(posedge wclk_i) disable iff (!lock_i)
        !valid_o |-> !aligned_o);

    // R8
    search_off_chk: assert property (@(posedge wclk_i) disable iff (!lock_i)
        !search_en_i |=> !aligned_o);

endmodule

bind dser_ddr_deserializer dser_ddr_deserializer_chk #(.BITS(BITS)) chk_i (
    .wclk_i      (wclk_i),
    .lock_i      (lock_i),
    .search_en_i (search_en_i),
    .train_pat_i (train_pat_i),
    .word_o      (word_o),
    .valid_o     (valid_o),
    .aligned_o   (aligned_o)
);

// File: tb/dser_ddr_deserializer_tb_top.sv
`timescale 1ns/1ps
// Bench: word clock 125 MHz (8 ns), fast clock 500 MHz, one time base.
// Stream bit j is driven at j+0.5 ns and sampled by the edge at j+1 ns.
module dser_ddr_deserializer_tb_top;

    localparam int RATIO = 4;
    localparam int BITS  = 2 * RATIO;

    logic            fclk = 1'b0;
    logic            wclk = 1'b0;
    logic            lock = 1'b0;
    logic            sdi  = 1'b0;
    logic            slip = 1'b0;
    logic            sen  = 1'b0;
    logic [BITS-1:0] pat  = 8'h1D;
    logic [BITS-1:0] word;
    logic            valid;
    logic            aligned;

    int     errs   = 0;
    int     checks = 0;
    int     mode   = 0;   // 0: hashed data, 1: repeating training pattern
    int     phase  = 0;
    longint tick   = 0;
    int     wm     = 0;   // word-clock rising edges seen

    dser_ddr_deserializer #(.RATIO(RATIO)) dut_i (
        .fclk_i      (fclk),
        .wclk_i      (wclk),
        .lock_i      (lock),
        .sdi_i       (sdi),
        .slip_i      (slip),
        .search_en_i (sen),
        .train_pat_i (pat),
        .word_o      (word),
        .valid_o     (valid),
        .aligned_o   (aligned)
    );

    initial forever #1 fclk = ~fclk;
    initial begin
        #1 wclk = 1'b1;
        forever #4 wclk = ~wclk;
    end
    always @(posedge wclk) wm <= wm + 1;

    function automatic logic bit_at(longint j);
        logic [31:0] h;
        if (mode == 1) begin
            return pat[7 - int'((j + phase) % 8)];
        end
        h = 32'(j) * 32'h9E3779B1;
        return h[13] ^ h[27] ^ h[5];
    endfunction

    // Word after the edge at 8m+1 ns: MSB = stream bit 8m-10-off (R3, R5)
    function automatic logic [BITS-1:0] exp_word(int off);
        logic [BITS-1:0] w;
        longint base;
        base = longint'(8 * wm - 18 - off);
        for (int k = 0; k < BITS; k++) begin
            w[BITS-1-k] = bit_at(base + k);
        end
        return w;
    endfunction

    initial begin
        #0.5;
        forever begin
            sdi = bit_at(tick);
            tick++;
            #1;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge wclk);
        #1;
    endtask

    task automatic release_lock();
        @(posedge wclk);
        #0.5 lock = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #1600000;
        checks++;
        errs++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int boff;
        int n;
        // R1: reset state
        repeat (3) step();
        check(word == '0, "R1 word", 32'(word), 0);
        check(!valid, "R1 valid", 32'(valid), 0);
        check(!aligned, "R1 aligned", 32'(aligned), 0);

        // R2: valid latency; R3/R5/R8: data order with search off
        release_lock();
        step(); check(!valid, "R2 edge1", 32'(valid), 0);
        step(); check(!valid, "R2 edge2", 32'(valid), 0);
        step(); check(valid, "R2 edge3", 32'(valid), 1);
        for (int i = 0; i < 16; i++) begin
            check(word == exp_word(0), "R3 R5 word", 32'(word), 32'(exp_word(0)));
            check(!aligned && valid, "R8 R2 flags", {30'd0, valid, aligned}, 2);
            step();
        end

        // R4: manual slip sweep over every offset and back to zero
        boff = 0;
        for (int k = 1; k <= BITS; k++) begin
            slip = 1'b1;
            step();
            slip = 1'b0;
            check(word == exp_word(boff), "R4 before", 32'(word), 32'(exp_word(boff)));
            boff = (boff + 1) % BITS;
            step();
            check(word == exp_word(boff), "R4 after", 32'(word), 32'(exp_word(boff)));
            step();
            check(word == exp_word(boff), "R4 hold", 32'(word), 32'(exp_word(boff)));
        end

        // R6/R7/R9: automatic search over all eight stream phases
        for (int p = 0; p < BITS; p++) begin
            lock = 1'b0;
            mode = 1;
            phase = p;
            sen = 1'b1;
            step(); step();
            check(word == '0 && !aligned, "R1 relock", {23'd0, aligned, word}, 0);
            release_lock();
            n = (p + 6) % BITS;
            repeat (3 + 3 * n) step();
            check(!aligned, "R6 early", 32'(aligned), 0);
            step();
            check(aligned, "R6 R7 rise", 32'(aligned), 1);
            check(word == pat, "R7 word", 32'(word), 32'(pat));
            for (int i = 0; i < 6; i++) begin
                step();
                check(word == pat && aligned, "R9 stay", {23'd0, aligned, word}, {23'd0, 1'b1, pat});
            end
            sen = 1'b0;
            step();
            check(!aligned, "R7 clear", 32'(aligned), 0);
        end

        lock = 1'b0;
        step(); step();
        check(word == '0 && !valid, "R1 final", {23'd0, valid, word}, 0);
        finish_run();
    end

endmodule